// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of binary semaphores that two independent ports, left and right, share. Each port has its own select, output enable, read/write strobe, a flag index and a one-bit write value. A port asks for a flag by writing 0 and gives it back by writing 1. It then reads the flag to learn whether the token is its own. The bank only records ownership. Nothing else in the chip is locked by it, so the software on both sides agrees what each flag protects.

Every flag keeps one request latch per side and a record of the current owner. The first request to reach a free flag takes the token. A request from the other side that arrives later is stored and waits. When the owner releases, a waiting request takes the token on that same clock edge, with no retry from its side. When a port reads, the bank captures the read value once, at the start of the read, and then holds it. To see a change, a poller must drop select or output enable and raise it again. All state is registered on one clock and cleared by a synchronous active-high reset.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag is free, with no request pending on either side. Both read ports idle at 8'hFF.
- R2: The 3-bit address picks one of eight flags. Activity on one flag never changes the ownership or the pending requests of any other flag.
- R3: A port writes when select is low and the write strobe is low, in every cycle where both hold. Only the write bit matters: 0 requests the flag and 1 releases it. With select high, or with the strobe high, the write bit has no effect.
- R4: A request on a free flag grants the token on that clock edge. The owning side reads 8'h00, and the other side, or any side reading a free flag, reads 8'hFF. The flag value is copied onto all eight data bits.
- R5: A request from the non-owning side leaves the owner unchanged and stays pending.
- R6: When the owner releases and the other side has a pending request, the token passes to the other side on the same clock edge.
- R7: If both sides request a free flag on the same clock edge, the left side gets the token and the right request stays pending.
- R8: At most one side holds any flag. A holder always has its own request set.
- R9: A read is active when select is low, output enable is low and the strobe is high. Read data is captured in the first active cycle and held unchanged while the read stays active. It returns to 8'hFF in the cycle after the read ends.
- R10: A pending request lasts until its side writes 1. A request withdrawn before the owner releases is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wr_n | input | 1 | Left write strobe, low = write, high = read |
| l_addr | input | 3 | Left flag index |
| l_wbit | input | 1 | Left write value (0 request, 1 release) |
| l_rdata | output | 8 | Left read data, flag replicated |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wr_n | input | 1 | Right write strobe, low = write, high = read |
| r_addr | input | 3 | Right flag index |
| r_wbit | input | 1 | Right write value (0 request, 1 release) |
| r_rdata | output | 8 | Right read data, flag replicated |

## Verification
A lost pending request shows up at the ports only at the owner's release. The waiting side then reads 8'hFF where 8'h00 is due, in the first read that starts after that edge. A wrong owner record shows on the very next fresh read on either side, as two owners or as a free flag that reads as held. A fault in the capture register shows while a read is held open: the data follows the flag in the middle of the read instead of staying frozen. The bench therefore keeps reads open across handovers and compares both read ports with a reference model on every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int FLAGS_DEFAULT = 8;
  localparam int RD_W_DEFAULT  = 8;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_wr_decode.sv
module sem_wr_decode #(
  parameter int N_FLAGS = sem_pkg::FLAGS_DEFAULT,
  localparam int IW = $clog2(N_FLAGS)
) (
  input  logic               sel_n,
  input  logic               wr_n,
  input  logic [IW-1:0]      addr,
  input  logic               wbit,
  output logic [N_FLAGS-1:0] set_req,
  output logic [N_FLAGS-1:0] clr_req
);
  // One-hot request/release strobes for the addressed flag.
  always_comb begin
    set_req = '0;
    clr_req = '0;
    if (!sel_n && !wr_n) begin
      if (wbit) clr_req[addr] = 1'b1;
      else      set_req[addr] = 1'b1;
    end
  end
endmodule

// File: rtl/sem_flag.sv
module sem_flag
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_set,
  input  logic l_clr,
  input  logic r_set,
  input  logic r_clr,
  output logic l_view,
  output logic r_view
);
  logic   req_l_q, req_r_q;
  logic   req_l_d, req_r_d;
  owner_e own_q, own_d;

  always_comb begin
    req_l_d = l_set ? 1'b1 : (l_clr ? 1'b0 : req_l_q);
    req_r_d = r_set ? 1'b1 : (r_clr ? 1'b0 : req_r_q);
    unique case (own_q)
      OWN_LEFT:  own_d = req_l_d ? OWN_LEFT  : (req_r_d ? OWN_RIGHT : OWN_NONE);
      OWN_RIGHT: own_d = req_r_d ? OWN_RIGHT : (req_l_d ? OWN_LEFT  : OWN_NONE);
      default:   own_d = req_l_d ? OWN_LEFT  : (req_r_d ? OWN_RIGHT : OWN_NONE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
      own_q   <= OWN_NONE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      own_q   <= own_d;
    end
  end

  // Active-low view: 0 means this side holds the token.
  assign l_view = (own_q != OWN_LEFT);
  assign r_view = (own_q != OWN_RIGHT);

  AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_LEFT) && !l_clr |=> (own_q == OWN_LEFT)); // R5
  AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_RIGHT) && !r_clr |=> (own_q == OWN_RIGHT)); // R5
  AST_HANDOFF_L2R: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_LEFT) && l_clr && req_r_q && !r_clr |=> (own_q == OWN_RIGHT)); // R6
  AST_HANDOFF_R2L: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_RIGHT) && r_clr && req_l_q && !l_clr |=> (own_q == OWN_LEFT)); // R6
  AST_LEFT_PRIO: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_NONE) && l_set && r_set |=> (own_q == OWN_LEFT) && req_r_q); // R7
  AST_OWNER_REQ: assert property (@(posedge clk) disable iff (rst)
    ((own_q == OWN_LEFT) -> req_l_q) && ((own_q == OWN_RIGHT) -> req_r_q)); // R8
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (rst)
    !req_r_q && !r_set |=> (own_q != OWN_RIGHT) || $past(own_q == OWN_RIGHT)); // R10
endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port #(
  parameter int N_FLAGS = sem_pkg::FLAGS_DEFAULT,
  parameter int RD_W    = sem_pkg::RD_W_DEFAULT,
  localparam int IW = $clog2(N_FLAGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_n,
  input  logic               oe_n,
  input  logic               wr_n,
  input  logic [IW-1:0]      addr,
  input  logic [N_FLAGS-1:0] view,
  output logic [RD_W-1:0]    rdata
);
  logic act, act_q;
  logic [RD_W-1:0] rd_q;

  assign act = !sel_n && !oe_n && wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      rd_q  <= '1;
    end else begin
      act_q <= act;
      if (!act)       rd_q <= '1;
      else if (!act_q) rd_q <= {RD_W{view[addr]}};
    end
  end

  assign rdata = rd_q;

  AST_RD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    act && act_q |=> $stable(rd_q)); // R9
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !act |=> (rd_q == '1)); // R9
  AST_RD_REPL: assert property (@(posedge clk) disable iff (rst)
    (rd_q == '0) || (rd_q == '1)); // R4
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int N_FLAGS = sem_pkg::FLAGS_DEFAULT,
  parameter int RD_W    = sem_pkg::RD_W_DEFAULT,
  localparam int IW = $clog2(N_FLAGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            l_sel_n,
  input  logic            l_oe_n,
  input  logic            l_wr_n,
  input  logic [IW-1:0]   l_addr,
  input  logic            l_wbit,
  output logic [RD_W-1:0] l_rdata,
  input  logic            r_sel_n,
  input  logic            r_oe_n,
  input  logic            r_wr_n,
  input  logic [IW-1:0]   r_addr,
  input  logic            r_wbit,
  output logic [RD_W-1:0] r_rdata
);
  logic [N_FLAGS-1:0] l_set, l_clr, r_set, r_clr;
  logic [N_FLAGS-1:0] l_view, r_view;

  sem_wr_decode #(.N_FLAGS(N_FLAGS)) u_wdec_l (
    .sel_n(l_sel_n), .wr_n(l_wr_n), .addr(l_addr), .wbit(l_wbit),
    .set_req(l_set), .clr_req(l_clr));

  sem_wr_decode #(.N_FLAGS(N_FLAGS)) u_wdec_r (
    .sel_n(r_sel_n), .wr_n(r_wr_n), .addr(r_addr), .wbit(r_wbit),
    .set_req(r_set), .clr_req(r_clr));

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst(rst),
      .l_set(l_set[g]), .l_clr(l_clr[g]),
      .r_set(r_set[g]), .r_clr(r_clr[g]),
      .l_view(l_view[g]), .r_view(r_view[g]));
  end

  sem_rd_port #(.N_FLAGS(N_FLAGS), .RD_W(RD_W)) u_rd_l (
    .clk(clk), .rst(rst), .sel_n(l_sel_n), .oe_n(l_oe_n), .wr_n(l_wr_n),
    .addr(l_addr), .view(l_view), .rdata(l_rdata));

  sem_rd_port #(.N_FLAGS(N_FLAGS), .RD_W(RD_W)) u_rd_r (
    .clk(clk), .rst(rst), .sel_n(r_sel_n), .oe_n(r_oe_n), .wr_n(r_wr_n),
    .addr(r_addr), .view(r_view), .rdata(r_rdata));

  AST_NO_DOUBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((l_view | r_view) == '1)); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (l_rdata == '1) && (r_rdata == '1)); // R1
endmodule

// File: tb/tb_sem_bank.sv
`timescale 1ns/1ps
module tb_sem_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel_n = 1, l_oe_n = 1, l_wr_n = 1, l_wbit = 1;
  logic r_sel_n = 1, r_oe_n = 1, r_wr_n = 1, r_wbit = 1;
  logic [2:0] l_addr = 0, r_addr = 0;
  wire  [7:0] l_rdata, r_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sem_bank dut (
    .clk(clk), .rst(rst),
    .l_sel_n(l_sel_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n), .l_addr(l_addr),
    .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n), .r_addr(r_addr),
    .r_wbit(r_wbit), .r_rdata(r_rdata));

  // Behavioural reference: 0 none, 1 left, 2 right
  int  own [8];
  bit  rq_l [8];
  bit  rq_r [8];
  bit  pact_l, pact_r, al, ar, nl, nr;
  logic [7:0] exp_l = 8'hFF, exp_r = 8'hFF;

  always @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < 8; f++) begin own[f] = 0; rq_l[f] = 0; rq_r[f] = 0; end
      pact_l = 0; pact_r = 0; exp_l = 8'hFF; exp_r = 8'hFF;
    end else begin
      al = !l_sel_n && !l_oe_n && l_wr_n;
      ar = !r_sel_n && !r_oe_n && r_wr_n;
      if (!al) exp_l = 8'hFF; else if (!pact_l) exp_l = (own[l_addr] == 1) ? 8'h00 : 8'hFF;
      if (!ar) exp_r = 8'hFF; else if (!pact_r) exp_r = (own[r_addr] == 2) ? 8'h00 : 8'hFF;
      pact_l = al; pact_r = ar;
      for (int f = 0; f < 8; f++) begin
        nl = rq_l[f]; nr = rq_r[f];
        if (!l_sel_n && !l_wr_n && l_addr == f) nl = !l_wbit;
        if (!r_sel_n && !r_wr_n && r_addr == f) nr = !r_wbit;
        if (own[f] == 1 && !nl) own[f] = nr ? 2 : 0;
        else if (own[f] == 2 && !nr) own[f] = nl ? 1 : 0;
        else if (own[f] == 0) own[f] = nl ? 1 : (nr ? 2 : 0);
        rq_l[f] = nl; rq_r[f] = nr;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 model left", l_rdata, exp_l);
      chk("R4 model right", r_rdata, exp_r);
    end
  end

  task automatic tick; @(negedge clk); endtask
  task automatic idle_l; l_sel_n = 1; l_oe_n = 1; l_wr_n = 1; l_addr = 0; l_wbit = 1; endtask
  task automatic idle_r; r_sel_n = 1; r_oe_n = 1; r_wr_n = 1; r_addr = 0; r_wbit = 1; endtask

  task automatic wr_l(input logic [2:0] a, input logic d);
    l_sel_n = 0; l_wr_n = 0; l_oe_n = 1; l_addr = a; l_wbit = d; tick; idle_l;
  endtask
  task automatic wr_r(input logic [2:0] a, input logic d);
    r_sel_n = 0; r_wr_n = 0; r_oe_n = 1; r_addr = a; r_wbit = d; tick; idle_r;
  endtask
  task automatic wr_both(input logic [2:0] a, input logic dl, input logic dr);
    l_sel_n = 0; l_wr_n = 0; l_addr = a; l_wbit = dl;
    r_sel_n = 0; r_wr_n = 0; r_addr = a; r_wbit = dr;
    tick; idle_l; idle_r;
  endtask
  task automatic rd_l(input logic [2:0] a, input logic [7:0] e, input string tag);
    l_sel_n = 0; l_oe_n = 0; l_wr_n = 1; l_addr = a; tick;
    chk(tag, l_rdata, e); idle_l; tick;
  endtask
  task automatic rd_r(input logic [2:0] a, input logic [7:0] e, input string tag);
    r_sel_n = 0; r_oe_n = 0; r_wr_n = 1; r_addr = a; tick;
    chk(tag, r_rdata, e); idle_r; tick;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst = 0;
    tick;
    chk("R1 idle left after reset", l_rdata, 8'hFF);
    chk("R1 idle right after reset", r_rdata, 8'hFF);
    for (int f = 0; f < 8; f++) rd_l(f[2:0], 8'hFF, "R1 free flag left");
    rd_r(3'd6, 8'hFF, "R1 free flag right");

    // R4 grant and replication, R5 pending, R6 handover
    wr_l(3'd3, 1'b0);
    rd_l(3'd3, 8'h00, "R4 left owner reads zero");
    rd_r(3'd3, 8'hFF, "R4 other side reads ones");
    wr_r(3'd3, 1'b0);
    rd_r(3'd3, 8'hFF, "R5 late request not granted");
    rd_l(3'd3, 8'h00, "R5 owner unchanged");
    wr_l(3'd3, 1'b1);
    rd_r(3'd3, 8'h00, "R6 pending right takes token");
    rd_l(3'd3, 8'hFF, "R6 left lost token");
    wr_r(3'd3, 1'b1);
    rd_l(3'd3, 8'hFF, "R6 free after release");

    // R7 simultaneous requests
    wr_both(3'd5, 1'b0, 1'b0);
    rd_l(3'd5, 8'h00, "R7 left wins tie");
    rd_r(3'd5, 8'hFF, "R7 right waits");
    wr_l(3'd5, 1'b1);
    rd_r(3'd5, 8'h00, "R7 right pending kept");
    wr_r(3'd5, 1'b1);

    // R3 writes ignored without select or strobe
    r_sel_n = 1; r_wr_n = 0; r_addr = 3'd1; r_wbit = 0; tick; idle_r;
    r_sel_n = 0; r_wr_n = 1; r_oe_n = 1; r_addr = 3'd1; r_wbit = 0; tick; idle_r;
    rd_r(3'd1, 8'hFF, "R3 ignored write right");
    wr_l(3'd1, 1'b0);
    rd_l(3'd1, 8'h00, "R3 no stray right request");
    wr_l(3'd1, 1'b1);
    rd_r(3'd1, 8'hFF, "R3 no stray right handover");

    // R10 withdrawn request
    wr_l(3'd2, 1'b0);
    wr_r(3'd2, 1'b0);
    wr_r(3'd2, 1'b1);
    wr_l(3'd2, 1'b1);
    rd_r(3'd2, 8'hFF, "R10 withdrawn request not granted");
    rd_l(3'd2, 8'hFF, "R10 flag free");

    // R9 held read across handover
    wr_l(3'd4, 1'b0);
    wr_r(3'd4, 1'b0);
    r_sel_n = 0; r_oe_n = 0; r_wr_n = 1; r_addr = 3'd4; tick;
    chk("R9 capture at start", r_rdata, 8'hFF);
    l_sel_n = 0; l_wr_n = 0; l_addr = 3'd4; l_wbit = 1; tick; idle_l;
    chk("R9 held during handover", r_rdata, 8'hFF);
    tick;
    chk("R9 still held", r_rdata, 8'hFF);
    r_oe_n = 1; tick;
    chk("R9 idle when disabled", r_rdata, 8'hFF);
    r_oe_n = 0; tick;
    chk("R9 fresh read shows token", r_rdata, 8'h00);
    idle_r; tick;
    wr_r(3'd4, 1'b1);

    // R2 independence, R8 single owner
    wr_l(3'd0, 1'b0);
    wr_r(3'd7, 1'b0);
    rd_l(3'd7, 8'hFF, "R2 left sees right flag");
    rd_r(3'd0, 8'hFF, "R2 right sees left flag");
    rd_l(3'd0, 8'h00, "R2 left flag kept");
    rd_r(3'd7, 8'h00, "R2 right flag kept");
    for (int f = 0; f < 8; f++) begin
      logic [7:0] lv, rv;
      l_sel_n = 0; l_oe_n = 0; l_wr_n = 1; l_addr = f[2:0];
      r_sel_n = 0; r_oe_n = 0; r_wr_n = 1; r_addr = f[2:0];
      tick; lv = l_rdata; rv = r_rdata; idle_l; idle_r; tick;
      chk("R8 not both owners", {7'd0, (lv == 8'h00) && (rv == 8'h00)}, 8'h00);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule